// File: doc/BRIEF.md
# Interleaved I/Q Receive Port Formatter

This block packs quadrature sample pairs onto one narrow output bus. Each pair holds an I word and a Q word that were taken at the same instant. The formatter places the two words on the bus in two consecutive cycles of its word-rate clock. A channel flag travels with the bus and tells the receiver which word is present. A forwarded clock travels with it too, so the receiver can capture the words.

Software settings choose five things:
- which word of the pair goes first;
- whether the flag is high or low while the I word is present;
- whether the forwarded clock is inverted;
- whether the forwarded clock runs at the word rate or at half the word rate, with a new word at each of its edges;
- whether only one channel is sent.

The settings are sampled only at a pair boundary. A pair is therefore never emitted under two different modes.

The block runs on a clock at the bus word rate, which is twice the sample-pair rate. A sample strobe marks a new pair and arrives at most once every two cycles.

Top module: `iq_rx_formatter`

## Requirements
- R1: During reset and in the first cycle after it, the bus word is 0 and the channel flag sits at its Q level. The Q level is the inverse of `mode_i_flag_high`.
- R2: With `mode_i_first`=1, a pair strobed at clock edge E puts its I word on the bus after edge E and its Q word after edge E+1.
- R3: With `mode_i_first`=0, the Q word goes out after edge E and the I word after edge E+1.
- R4: The flag is 1 while the I word is on the bus when `mode_i_flag_high`=1, and 0 while the I word is on the bus when `mode_i_flag_high`=0. The Q word always gets the opposite level. All four combinations of order and polarity work.
- R5: In a cycle where no pair word is being sent, the bus word is 0 and the flag is at its Q level.
- R6: A change to any mode input during the second word of a pair takes effect only from the next pair.
- R7: In word-rate clock mode (`mode_ddr`=0), the forwarded clock follows the internal clock. It is high in the first half of each cycle and low in the second half, so data changes on its rising edge. With `mode_clk_inv`=1 both levels are swapped, so data changes on its falling edge.
- R8: In half-rate mode (`mode_ddr`=1), the forwarded clock changes level once per word cycle, so a word is launched at each of its edges. `mode_clk_inv`=1 inverts it.
- R9: With `mode_single`=1, only one channel is sent: I when `mode_single_q`=0, Q when `mode_single_q`=1. The chosen word is held for both cycles of the pair, and the flag shows the level of that channel. This works in both clock modes.
- R10: When strobes arrive exactly every two cycles, the output carries the words of consecutive pairs with no gap. The strobe must never be high in two adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock (twice the pair rate) |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Strobe marking a new I/Q pair |
| smp_i | input | 12 | I sample of the pair |
| smp_q | input | 12 | Q sample of the pair |
| mode_i_first | input | 1 | 1: I word first; 0: Q word first |
| mode_i_flag_high | input | 1 | 1: flag high with I; 0: flag low with I |
| mode_clk_inv | input | 1 | Invert the forwarded clock |
| mode_ddr | input | 1 | Forwarded clock at half the word rate |
| mode_single | input | 1 | Send one channel only |
| mode_single_q | input | 1 | In single mode, 0 sends I, 1 sends Q |
| port_word | output | 12 | Interleaved output bus |
| port_chan | output | 1 | Channel flag |
| port_clk | output | 1 | Forwarded qualifying clock |

## Verification
Pairs are sent with distinct I and Q values under all four combinations of order and polarity. A word swap, a wrong flag phase and a stale-register fault therefore each show up as a different mismatch.

One pair has its mode changed between its two words. This separates sampling the settings at the boundary from using them live. Back-to-back pairs show that the output has no gaps and no repeated words, and idle cycles after a pair show that the bus returns to zero.

Single-channel runs select I and then Q, in both clock modes. The forwarded clock is sampled in both halves of a cycle to check its phase, and in consecutive cycles to check the half-rate toggle.

// File: rtl/iqf_pkg.sv
// Shared types for the I/Q receive formatter.
// Assumes: all mode fields are plain run-time levels.
package iqf_pkg;

    typedef struct packed {
        logic i_first;
        logic i_flag_high;
        logic clk_inv;
        logic ddr;
        logic single;
        logic single_q;
    } iqf_mode_t;

endpackage

// File: rtl/iqf_capture.sv
// Captures a strobed I/Q pair and the mode settings at the pair boundary.
// Tracks which half of the pair is due next.
// Assumes: the strobe is never high in two adjacent cycles.
module iqf_capture
    import iqf_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [WORD_W-1:0] smp_i,
    input  logic [WORD_W-1:0] smp_q,
    input  iqf_mode_t         mode_live,
    output logic              second_due,
    output logic [WORD_W-1:0] hold_i,
    output logic [WORD_W-1:0] hold_q,
    output iqf_mode_t         mode_held
);

    // Marks the cycle that must emit the second word of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) second_due <= 1'b0;
        else        second_due <= smp_vld;
    end

    // Keeps both words of the pair for the second slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_i <= '0;
            hold_q <= '0;
        end else if (smp_vld) begin
            hold_i <= smp_i;
            hold_q <= smp_q;
        end
    end

    // Samples the mode settings only outside the second slot (a pair boundary).
    always_ff @(posedge clk) begin
        if (!second_due) mode_held <= mode_live;
    end

    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> !smp_vld); // R10

    AST_MODE_HELD_IN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        second_due |=> (mode_held == $past(mode_held))); // R6

endmodule

// File: rtl/iqf_word_pick.sv
// Chooses the word and flag level for one bus slot.
// Assumes: slot 0 is the first word of a pair and slot 1 the second.
module iqf_word_pick
    import iqf_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              slot,
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] word_q,
    input  iqf_mode_t         mode,
    output logic [WORD_W-1:0] word_out,
    output logic              flag_out
);

    logic take_i;

    // Decides whether this slot carries the I channel.
    always_comb begin
        if (mode.single) take_i = !mode.single_q;
        else             take_i = slot ? !mode.i_first : mode.i_first;
    end

    // Drives the chosen word and the flag level for that channel.
    always_comb begin
        word_out = take_i ? word_i : word_q;
        flag_out = take_i ? mode.i_flag_high : !mode.i_flag_high;
    end

endmodule

// File: rtl/iqf_fwd_clk.sv
// Makes the forwarded qualifying clock.
// Word-rate mode passes the internal clock through a polarity select.
// Half-rate mode uses a register that toggles on every word.
// Assumes: mode inputs change only at pair boundaries.
module iqf_fwd_clk (
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate,
    input  logic invert,
    output logic fwd_clk
);

    logic tog_q;

    // Toggles once per word cycle; this register is the half-rate clock.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= !tog_q;
    end

    // Selects the clock source and applies the polarity.
    always_comb begin
        fwd_clk = (half_rate ? tog_q : clk) ^ invert;
    end

    AST_HALF_RATE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (half_rate && $past(half_rate) && $stable(invert)) |-> (fwd_clk != $past(fwd_clk))); // R8

endmodule

// File: rtl/iq_rx_formatter.sv
// Interleaved I/Q receive port formatter.
// Puts simultaneous I/Q pairs onto one bus, with a channel flag and a forwarded clock.
// Assumes: clk runs at the word rate, and smp_vld is high at most once every two cycles.
module iq_rx_formatter
    import iqf_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [WORD_W-1:0] smp_i,
    input  logic [WORD_W-1:0] smp_q,
    input  logic              mode_i_first,
    input  logic              mode_i_flag_high,
    input  logic              mode_clk_inv,
    input  logic              mode_ddr,
    input  logic              mode_single,
    input  logic              mode_single_q,
    output logic [WORD_W-1:0] port_word,
    output logic              port_chan,
    output logic              port_clk
);

    iqf_mode_t         mode_live;
    iqf_mode_t         mode_held;
    iqf_mode_t         pick_mode;
    logic              second_due;
    logic [WORD_W-1:0] hold_i;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] pick_i;
    logic [WORD_W-1:0] pick_q;
    logic [WORD_W-1:0] pick_word;
    logic              pick_flag;

    // Bundles the mode inputs.
    always_comb begin
        mode_live = '{i_first: mode_i_first, i_flag_high: mode_i_flag_high,
                      clk_inv: mode_clk_inv, ddr: mode_ddr,
                      single: mode_single, single_q: mode_single_q};
    end

    iqf_capture #(.WORD_W(WORD_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .smp_i      (smp_i),
        .smp_q      (smp_q),
        .mode_live  (mode_live),
        .second_due (second_due),
        .hold_i     (hold_i),
        .hold_q     (hold_q),
        .mode_held  (mode_held)
    );

    // First slot uses the live pair and mode; the second slot uses the held copies.
    always_comb begin
        pick_i    = smp_vld ? smp_i : hold_i;
        pick_q    = smp_vld ? smp_q : hold_q;
        pick_mode = smp_vld ? mode_live : mode_held;
    end

    iqf_word_pick #(.WORD_W(WORD_W)) u_pick (
        .slot     (!smp_vld),
        .word_i   (pick_i),
        .word_q   (pick_q),
        .mode     (pick_mode),
        .word_out (pick_word),
        .flag_out (pick_flag)
    );

    // Registers the bus word and flag; outside a pair it drives zero and the Q level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_word <= '0;
            port_chan <= !mode_i_flag_high;
        end else if (smp_vld || second_due) begin
            port_word <= pick_word;
            port_chan <= pick_flag;
        end else begin
            port_word <= '0;
            port_chan <= !mode_i_flag_high;
        end
    end

    iqf_fwd_clk u_fwd_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_rate (mode_held.ddr),
        .invert    (mode_held.clk_inv),
        .fwd_clk   (port_clk)
    );

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !second_due) |=> (port_word == '0)); // R5

    AST_FLAG_FLIPS_IN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (second_due && !mode_held.single) |=> (port_chan != $past(port_chan))); // R4

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (second_due && mode_held.single) |=> $stable(port_word)); // R9

endmodule

// File: tb/iq_rx_formatter_bench.sv
`timescale 1ns/1ps
module iq_rx_formatter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_i = '0;
    logic [11:0] smp_q = '0;
    logic        m_ifirst = 1'b1;
    logic        m_ihigh = 1'b1;
    logic        m_inv = 1'b0;
    logic        m_ddr = 1'b0;
    logic        m_single = 1'b0;
    logic        m_selq = 1'b0;
    logic [11:0] port_word;
    logic        port_chan;
    logic        port_clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    iq_rx_formatter u_iq_rx_formatter (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
        .mode_i_first(m_ifirst), .mode_i_flag_high(m_ihigh), .mode_clk_inv(m_inv),
        .mode_ddr(m_ddr), .mode_single(m_single), .mode_single_q(m_selq),
        .port_word(port_word), .port_chan(port_chan), .port_clk(port_clk)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected word/flag for a slot, computed from the requirements.
    task automatic expect_slot(input bit slot, input logic [11:0] i, input logic [11:0] q,
                               input bit ifirst, input bit ihigh, input bit single, input bit selq,
                               output logic [11:0] w, output bit f);
        bit is_i;
        is_i = single ? !selq : (slot ? !ifirst : ifirst);
        w = is_i ? i : q;
        f = is_i ? ihigh : !ihigh;
    endtask

    // Sends one pair (called at a negedge) and checks both slots.
    task automatic send_pair(input string req, input logic [11:0] i, input logic [11:0] q);
        logic [11:0] w0, w1;
        bit f0, f1;
        expect_slot(0, i, q, m_ifirst, m_ihigh, m_single, m_selq, w0, f0);
        expect_slot(1, i, q, m_ifirst, m_ihigh, m_single, m_selq, w1, f1);
        smp_vld = 1'b1; smp_i = i; smp_q = q;
        @(negedge clk);
        chk({req, " word0"}, port_word, w0);
        chk({req, " flag0"}, port_chan, f0);
        smp_vld = 1'b0;
        @(negedge clk);
        chk({req, " word1"}, port_word, w1);
        chk({req, " flag1"}, port_chan, f1);
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk({req, " idle word"}, port_word, 0);
        chk({req, " idle flag"}, port_chan, !m_ihigh);
    endtask

    task automatic t_reset;
        m_ihigh = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset word", port_word, 0);
        chk("R1 reset flag", port_chan, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset word", port_word, 0);
        chk("R1 post-reset flag", port_chan, 0);
    endtask

    task automatic t_four_modes;
        for (int k = 0; k < 4; k++) begin
            m_ifirst = k[0];
            m_ihigh = k[1];
            @(negedge clk);
            send_pair(m_ifirst ? "R2 R4 order" : "R3 R4 order", 12'h100 + 12'(k), 12'hA00 + 12'(k));
        end
    endtask

    task automatic t_idle;
        m_ifirst = 1'b1; m_ihigh = 1'b0;
        @(negedge clk);
        send_pair("R5 lead", 12'h5A5, 12'h3C3);
        idle_check("R5");
        idle_check("R5");
    endtask

    task automatic t_boundary;
        m_ifirst = 1'b1; m_ihigh = 1'b1;
        @(negedge clk);
        smp_vld = 1'b1; smp_i = 12'h111; smp_q = 12'h222;
        @(negedge clk);
        chk("R6 first word", port_word, 12'h111);
        smp_vld = 1'b0;
        m_ifirst = 1'b0; m_ihigh = 1'b0;
        @(negedge clk);
        chk("R6 second word old order", port_word, 12'h222);
        chk("R6 second flag old polarity", port_chan, 0);
        send_pair("R6 next pair new mode", 12'h333, 12'h444);
    endtask

    task automatic t_back_to_back;
        m_ifirst = 1'b0; m_ihigh = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++)
            send_pair("R10 back-to-back", 12'h700 + 12'(k), 12'h070 + 12'(k));
        idle_check("R10 end");
    endtask

    task automatic t_clk_bus;
        for (int v = 0; v < 2; v++) begin
            m_ddr = 1'b0; m_inv = v[0];
            repeat (2) @(negedge clk);
            #1 chk("R7 fwd clk low half", port_clk, v);
            @(posedge clk);
            #1 chk("R7 fwd clk high half", port_clk, !v[0]);
        end
    endtask

    task automatic t_ddr;
        logic s0, s1, s2;
        m_ddr = 1'b1; m_inv = 1'b0;
        repeat (2) @(negedge clk);
        #1 s0 = port_clk;
        @(negedge clk);
        #1 s1 = port_clk;
        chk("R8 toggle per word", s1, !s0);
        m_inv = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1 s2 = port_clk;
        chk("R8 inverted", s2, s0);
        @(negedge clk);
        send_pair("R8 words in half-rate mode", 12'h9AB, 12'h0CD);
    endtask

    task automatic t_single;
        m_single = 1'b1; m_ihigh = 1'b1;
        for (int d = 0; d < 2; d++) begin
            m_ddr = d[0];
            m_selq = 1'b0;
            @(negedge clk);
            send_pair("R9 single I", 12'h4E1, 12'h2B2);
            m_selq = 1'b1;
            @(negedge clk);
            send_pair("R9 single Q", 12'h4E3, 12'h2B4);
        end
        m_single = 1'b0; m_ddr = 1'b0; m_inv = 1'b0;
    endtask

    initial begin
        t_reset();
        t_four_modes();
        t_idle();
        t_boundary();
        t_back_to_back();
        t_clk_bus();
        t_ddr();
        t_single();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule